// File: doc/BRIEF.md
# Pipelined Core Interrupt Detection Controller

This block watches a bank of interrupt request pins on behalf of a deeply pipelined processor core and decides when one of them may be taken. A rising level on a pin is turned into a one-shot edge. The edge passes through a fixed-length delay line and then lands in a per-source pending flag, but only on a CPU cycle boundary, which the core marks with a step strobe. Source 0 is the nonmaskable source. Every other source is maskable.

A pending flag can only win when both enables allow it. The nonmaskable enable governs every source. The global enable additionally governs sources 1 and up. The core reports for each advancing execute packet whether it holds a branch or sits in a branch delay slot. The controller remembers the last five such reports and refuses to take anything while any of them is set.

When a source is taken, the controller pulses an acknowledge, presents the source index, requests a fetch from the service vector and asks the pipeline to annul the packets in flight. All of these last one clock. It then keeps a fixed quiet window during which no further source may be taken.

Top module: `icd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, flags_o, iack_o, inum_o, vec_fetch_o and annul_o are all zero.
- R2: A pin first sampled high at clock edge P (it was low at the edge before) shows its flag bit set in flags_o after edge P+4 when step_i is held high. A pin that then stays high never sets its flag again.
- R3: If step_i is low when the 4-clock delay ends, the flag stays clear and sets at the first clock edge at which step_i is high.
- R4: With nmie_i low, no source is taken (iack_o stays low) and pending flags stay set. Once nmie_i rises with a flag pending and nothing else blocking, the take happens at the next clock edge.
- R5: With gie_i low and nmie_i high, sources 1 to 11 are not taken, but source 0 is still taken.
- R6: pkt_branch_i is sampled at every clock edge where step_i is high. A take requires the last five such samples to be zero. After the last set sample is shifted in, the pending source is taken at the sixth stepping edge that follows.
- R7: A take raises iack_o, vec_fetch_o and annul_o for exactly one clock, and inum_o holds the taken source index during that clock.
- R8: Among enabled pending flags the lowest index wins. Only that flag is cleared by the take, and the other flags stay set.
- R9: After a take, the next seven stepping edges cannot start another take. With step_i held high, a source waiting throughout is taken exactly 8 clocks after the previous take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_pin_i | input | 12 | Interrupt request pins, bit 0 is the nonmaskable source |
| gie_i | input | 1 | Global enable for maskable sources |
| nmie_i | input | 1 | Enable for all nonreset sources |
| step_i | input | 1 | CPU cycle boundary / pipeline advance strobe |
| pkt_branch_i | input | 1 | Advancing packet holds a branch or is in a delay slot |
| iack_o | output | 1 | One-clock acknowledge of a taken source |
| inum_o | output | 4 | Index of the taken source |
| vec_fetch_o | output | 1 | Request fetch of the service vector packet |
| annul_o | output | 1 | Request annulment of in-flight packets |
| flags_o | output | 12 | Pending flag per source |

## Verification
The hardest state to reach from the ports is a source that is fully pending and enabled but held back by a single branch report that is still inside the five-deep history. Reaching it takes care, because raising the enable in the same cycle as the branch report would let the take slip through first. The stimulus first parks the flag with the nonmaskable enable low and injects one branch report. It then opens the enable on the next cycle and counts the clocks until the acknowledge. The quiet window is reached by pending three sources at once, so that two more are still waiting right after the first take.

// File: rtl/icd_pkg.sv
package icd_pkg;

    localparam int unsigned SRC_N_DEF     = 12;
    localparam int unsigned EDGE_LAT_DEF  = 4;
    localparam int unsigned HIST_LEN_DEF  = 5;
    localparam int unsigned QUIET_LEN_DEF = 7;

    typedef enum logic {
        SEQ_OPEN,
        SEQ_QUIET
    } seq_state_e;

    typedef struct packed {
        logic ack;
        logic fetch;
        logic annul;
    } take_pulse_t;

    // index 0 is the nonmaskable source
    function automatic logic src_maskable(input int unsigned idx);
        return idx != 0;
    endfunction

endpackage

// File: rtl/icd_src_chain.sv
module icd_src_chain #(
    parameter int unsigned EDGE_LAT = icd_pkg::EDGE_LAT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic step_i,
    input  logic clr_i,
    output logic flag_o
);
    logic                pin_q;
    logic                edge_w;
    logic [EDGE_LAT-1:0] dly_q;
    logic                hold_q;
    logic                flag_q;
    logic                rdy_w;

    assign edge_w = pin_i & ~pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_i;
    end

    generate
        if (EDGE_LAT == 1) begin : g_dly_one
            always_ff @(posedge clk) begin
                if (rst) dly_q <= '0;
                else     dly_q <= edge_w;
            end
        end else begin : g_dly_line
            always_ff @(posedge clk) begin
                if (rst) dly_q <= '0;
                else     dly_q <= {dly_q[EDGE_LAT-2:0], edge_w};
            end
        end
    endgenerate

    // delay done, waiting for (or at) a cycle boundary
    assign rdy_w = dly_q[EDGE_LAT-1] | hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            hold_q <= rdy_w & ~step_i;
            flag_q <= (flag_q & ~clr_i) | (rdy_w & step_i);
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/icd_branch_hist.sv
module icd_branch_hist #(
    parameter int unsigned DEPTH = icd_pkg::HIST_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    input  logic br_i,
    output logic clear_o
);
    logic [DEPTH-1:0] hist_q;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)         hist_q <= '0;
                else if (step_i) hist_q <= br_i;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst)         hist_q <= '0;
                else if (step_i) hist_q <= {hist_q[DEPTH-2:0], br_i};
            end
        end
    endgenerate

    assign clear_o = ~|hist_q;
endmodule

// File: rtl/icd_take_seq.sv
module icd_take_seq
    import icd_pkg::*;
#(
    parameter int unsigned SRC_N     = SRC_N_DEF,
    parameter int unsigned QUIET_LEN = QUIET_LEN_DEF,
    parameter int unsigned IDX_W     = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] flags_i,
    input  logic             gie_i,
    input  logic             nmie_i,
    input  logic             step_i,
    input  logic             br_clear_i,
    output logic [SRC_N-1:0] clr_o,
    output logic             iack_o,
    output logic [IDX_W-1:0] inum_o,
    output logic             fetch_o,
    output logic             annul_o
);
    localparam int unsigned CNT_W = $clog2(QUIET_LEN + 1);
    localparam logic [CNT_W-1:0] QUIET_INIT = CNT_W'(QUIET_LEN);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    take_pulse_t      pulse_q;
    logic [IDX_W-1:0] inum_q;
    logic [SRC_N-1:0] elig_w;
    logic [IDX_W-1:0] pick_w;
    logic             found_w;
    logic             take_w;

    always_comb begin
        for (int unsigned i = 0; i < SRC_N; i++) begin
            elig_w[i] = flags_i[i] & nmie_i & (src_maskable(i) ? gie_i : 1'b1);
        end
    end

    always_comb begin
        pick_w = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (elig_w[i]) pick_w = IDX_W'(i);
        end
    end

    assign found_w = |elig_w;
    assign take_w  = step_i & br_clear_i & (state_q == SEQ_OPEN) & found_w;

    generate
        for (genvar g = 0; g < SRC_N; g++) begin : g_clr
            assign clr_o[g] = take_w & (pick_w == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OPEN;
            cnt_q   <= '0;
            pulse_q <= '0;
            inum_q  <= '0;
        end else begin
            pulse_q <= '{ack: take_w, fetch: take_w, annul: take_w};
            if (take_w) inum_q <= pick_w;
            case (state_q)
                SEQ_OPEN: begin
                    if (take_w) begin
                        state_q <= SEQ_QUIET;
                        cnt_q   <= QUIET_INIT;
                    end
                end
                SEQ_QUIET: begin
                    if (step_i) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            state_q <= SEQ_OPEN;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end
                    end
                end
                default: state_q <= SEQ_OPEN;
            endcase
        end
    end

    assign iack_o  = pulse_q.ack;
    assign fetch_o = pulse_q.fetch;
    assign annul_o = pulse_q.annul;
    assign inum_o  = inum_q;
endmodule

// File: rtl/icd_ctrl.sv
module icd_ctrl
    import icd_pkg::*;
#(
    parameter int unsigned SRC_N     = SRC_N_DEF,
    parameter int unsigned EDGE_LAT  = EDGE_LAT_DEF,
    parameter int unsigned HIST_LEN  = HIST_LEN_DEF,
    parameter int unsigned QUIET_LEN = QUIET_LEN_DEF,
    parameter int unsigned IDX_W     = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] int_pin_i,
    input  logic             gie_i,
    input  logic             nmie_i,
    input  logic             step_i,
    input  logic             pkt_branch_i,
    output logic             iack_o,
    output logic [IDX_W-1:0] inum_o,
    output logic             vec_fetch_o,
    output logic             annul_o,
    output logic [SRC_N-1:0] flags_o
);
    logic [SRC_N-1:0] flag_w;
    logic [SRC_N-1:0] clr_w;
    logic             br_clear_w;

    generate
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            icd_src_chain #(.EDGE_LAT(EDGE_LAT)) u_chain (
                .clk    (clk),
                .rst    (rst),
                .pin_i  (int_pin_i[s]),
                .step_i (step_i),
                .clr_i  (clr_w[s]),
                .flag_o (flag_w[s])
            );
        end
    endgenerate

    icd_branch_hist #(.DEPTH(HIST_LEN)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_i),
        .br_i    (pkt_branch_i),
        .clear_o (br_clear_w)
    );

    icd_take_seq #(
        .SRC_N     (SRC_N),
        .QUIET_LEN (QUIET_LEN),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .flags_i    (flag_w),
        .gie_i      (gie_i),
        .nmie_i     (nmie_i),
        .step_i     (step_i),
        .br_clear_i (br_clear_w),
        .clr_o      (clr_w),
        .iack_o     (iack_o),
        .inum_o     (inum_o),
        .fetch_o    (vec_fetch_o),
        .annul_o    (annul_o)
    );

    assign flags_o = flag_w;
endmodule

// File: rtl/icd_ctrl_chk.sv
module icd_ctrl_chk #(
    parameter int unsigned SRC_N     = 12,
    parameter int unsigned HIST_LEN  = 5,
    parameter int unsigned QUIET_LEN = 7,
    parameter int unsigned IDX_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             gie_i,
    input logic             nmie_i,
    input logic             step_i,
    input logic             pkt_branch_i,
    input logic             iack_o,
    input logic [IDX_W-1:0] inum_o,
    input logic             vec_fetch_o,
    input logic [SRC_N-1:0] flags_o
);
    localparam int unsigned GAP_W = $clog2(QUIET_LEN + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(QUIET_LEN);

    logic [HIST_LEN-1:0] seen_q;
    logic [GAP_W-1:0]    gap_q;
    logic                seen_clear;

    always_ff @(posedge clk) begin
        if (rst)         seen_q <= '0;
        else if (step_i) seen_q <= (seen_q << 1) | HIST_LEN'(pkt_branch_i);
    end
    assign seen_clear = (seen_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                            gap_q <= GAP_MAX;
        else if (iack_o)                    gap_q <= '0;
        else if (step_i && gap_q < GAP_MAX) gap_q <= gap_q + GAP_W'(1);
    end

    // R7
    iack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        iack_o |=> !iack_o);
    // R7
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vec_fetch_o |=> !vec_fetch_o);
    // R4
    nmie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        iack_o |-> $past(nmie_i));
    // R5
    gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (iack_o && inum_o != '0) |-> $past(gie_i));
    // R6
    branch_gate_chk: assert property (@(posedge clk) disable iff (rst)
        iack_o |-> ($past(seen_clear) && $past(step_i)));
    // R8
    winner_flag_chk: assert property (@(posedge clk) disable iff (rst)
        iack_o |-> ((($past(flags_o) >> inum_o) & SRC_N'(1)) != '0));
    // R9
    quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
        iack_o |-> (gap_q >= GAP_MAX));
endmodule

bind icd_ctrl icd_ctrl_chk #(
    .SRC_N     (SRC_N),
    .HIST_LEN  (HIST_LEN),
    .QUIET_LEN (QUIET_LEN),
    .IDX_W     (IDX_W)
) u_icd_chk (
    .clk          (clk),
    .rst          (rst),
    .gie_i        (gie_i),
    .nmie_i       (nmie_i),
    .step_i       (step_i),
    .pkt_branch_i (pkt_branch_i),
    .iack_o       (iack_o),
    .inum_o       (inum_o),
    .vec_fetch_o  (vec_fetch_o),
    .flags_o      (flags_o)
);

// File: tb/test_icd_ctrl.sv
`timescale 1ns/1ps
module test_icd_ctrl;
    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  int_pin;
    logic          gie, nmie, step, br;
    logic          iack, fetch, annul;
    logic [3:0]    inum;
    logic [N-1:0]  flags;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    icd_ctrl i_icd_ctrl (
        .clk          (clk),
        .rst          (rst),
        .int_pin_i    (int_pin),
        .gie_i        (gie),
        .nmie_i       (nmie),
        .step_i       (step),
        .pkt_branch_i (br),
        .iack_o       (iack),
        .inum_o       (inum),
        .vec_fetch_o  (fetch),
        .annul_o      (annul),
        .flags_o      (flags)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int hits = 0;
        for (int k = 0; k < n; k++) begin
            cyc(1);
            if (iack) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic take_chk(input logic [3:0] idx, input string req);
        chk(iack === 1'b1 && fetch === 1'b1 && annul === 1'b1, req, {iack, fetch, annul}, 3'b111);
        chk(inum === idx, req, inum, idx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; int_pin = '0; gie = 1'b0; nmie = 1'b0; step = 1'b1; br = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; int_pin = '0; gie = 1'b0; nmie = 1'b0; step = 1'b1; br = 1'b0;
        cyc(3);
        chk(flags === '0 && iack === 1'b0 && fetch === 1'b0 && annul === 1'b0 && inum === '0,
            "R1 in reset", {flags, iack, fetch, annul, inum}, 0);
        rst = 1'b0;
        cyc(1);
        chk(flags === '0 && iack === 1'b0 && inum === '0, "R1 after reset", {flags, iack, inum}, 0);
    endtask

    task automatic t_latency();
        do_reset();
        int_pin[3] = 1'b1;
        cyc(4);
        chk(flags === '0, "R2 flag not before delay", flags, 0);
        cyc(1);
        chk(flags === 12'h008, "R2 flag after delay", flags, 12'h008);
        nmie = 1'b1; gie = 1'b1;
        cyc(1);
        take_chk(4'd3, "R2 take of delayed flag");
        cyc(10);
        chk(flags === '0, "R2 held level no retrigger", flags, 0);
    endtask

    task automatic t_boundary();
        do_reset();
        step = 1'b0;
        int_pin[6] = 1'b1;
        cyc(8);
        chk(flags === '0, "R3 flag waits for boundary", flags, 0);
        step = 1'b1;
        cyc(1);
        chk(flags === 12'h040, "R3 flag at boundary", flags, 12'h040);
    endtask

    task automatic t_nmie();
        do_reset();
        gie = 1'b1;
        int_pin[0] = 1'b1; int_pin[5] = 1'b1;
        expect_quiet(10, "R4 nmie low blocks all");
        chk(flags === 12'h021, "R4 flags stay pending", flags, 12'h021);
        nmie = 1'b1;
        cyc(1);
        take_chk(4'd0, "R4 take after nmie rises");
    endtask

    task automatic t_gie();
        do_reset();
        nmie = 1'b1;
        int_pin[4] = 1'b1;
        expect_quiet(10, "R5 gie low blocks maskable");
        chk(flags === 12'h010, "R5 maskable pending", flags, 12'h010);
        int_pin[0] = 1'b1;
        cyc(6);
        take_chk(4'd0, "R5 nonmaskable taken with gie low");
        chk(flags === 12'h010, "R5 maskable kept", flags, 12'h010);
        gie = 1'b1;
        expect_quiet(7, "R9 window after nonmaskable take");
        cyc(1);
        take_chk(4'd4, "R5 maskable after gie rises");
    endtask

    task automatic t_branch();
        do_reset();
        br = 1'b1; nmie = 1'b1; gie = 1'b1;
        int_pin[8] = 1'b1;
        expect_quiet(12, "R6 branches block take");
        br = 1'b0;
        expect_quiet(5, "R6 history draining");
        cyc(1);
        take_chk(4'd8, "R6 take after branches clear");
        // single branch report with a parked flag
        nmie = 1'b0;
        cyc(10);
        int_pin[9] = 1'b1;
        cyc(8);
        chk(flags === 12'h200, "R6 parked flag", flags, 12'h200);
        br = 1'b1;
        cyc(1);
        br = 1'b0; nmie = 1'b1;
        expect_quiet(5, "R6 single branch blocks");
        cyc(1);
        take_chk(4'd9, "R6 take after single branch");
    endtask

    task automatic t_prio_window();
        do_reset();
        int_pin[2] = 1'b1; int_pin[7] = 1'b1; int_pin[9] = 1'b1;
        cyc(8);
        chk(flags === 12'h284, "R8 three pending", flags, 12'h284);
        nmie = 1'b1; gie = 1'b1;
        cyc(1);
        take_chk(4'd2, "R8 lowest index wins");
        chk(flags === 12'h280, "R8 only winner cleared", flags, 12'h280);
        cyc(1);
        chk(iack === 1'b0 && fetch === 1'b0 && annul === 1'b0, "R7 one clock pulse",
            {iack, fetch, annul}, 0);
        expect_quiet(6, "R9 quiet window");
        cyc(1);
        take_chk(4'd7, "R9 next take at 8 clocks");
        expect_quiet(7, "R9 second window");
        cyc(1);
        take_chk(4'd9, "R9 third take");
        chk(flags === '0, "R8 all cleared", flags, 0);
    endtask

    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; int_pin = '0; gie = 1'b0; nmie = 1'b0; step = 1'b1; br = 1'b0;
        t_reset();
        t_latency();
        t_boundary();
        t_nmie();
        t_gie();
        t_branch();
        t_prio_window();
        cyc(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule